// File: doc/BRIEF.md
# Serial Transceiver with Handshaked Status Flags

This block is an asynchronous serial transmitter and receiver sitting behind a small byte-wide register bus. Software writes a byte to the transmit holding register. The block moves it into a shifter and sends a frame made of these parts:

- a start bit;
- eight data bits, least significant first;
- an optional tenth bit, which is either parity or a multiprocessor (address/data) marker;
- one or two stop bits.

The receiver oversamples the line at sixteen ticks per bit. It rebuilds the same frame and latches the data byte, the marker bit and any error it finds.

Software reads a status byte that reports these flags:

- framing error;
- parity error;
- transmit complete;
- the marker bit last received;
- the marker bit to be sent.

An error flag cannot be cleared by a blind write. A read must first have seen the flag at 1, and a later write of 0 then clears it. An external transfer controller can write the transmit holding register directly. Such a write retires the transmit-complete flag in the same way a software commit does.

The status byte has this layout:

| Bit | Meaning |
|-----|---------|
| 7 | transmit register empty (`TDRE`) |
| 6, 5 | read as zero |
| 4 | framing error |
| 3 | parity error |
| 2 | transmit complete |
| 1 | received marker |
| 0 | marker to send |

The bus addresses are:

| `bus_addr` | Read | Write |
|------------|------|-------|
| 0 | holding register | holding register |
| 1 | received byte | — |
| 2 | status | status |

Top module: `serial_status_uart`

## Requirements
- R1: After reset the status byte at address 2 reads 8'h84, and `txd` is high.
- R2: A transmitted frame has the following parts, each bit lasting 16 `baud_tick` pulses:
  - a low start bit;
  - the 8 data bits, least significant bit first;
  - a tenth bit, present only when `par_en` or `mp_mode` is set;
  - one high stop bit, or two when `two_stop` is set.
- R3: With `par_en` set and `mp_mode` clear, the parity bit is the XOR of the data bits for even parity (`par_odd`=0), or its complement for odd parity. A received frame whose parity bit differs from this sets status bit 3.
- R4: A received frame whose first stop bit is sampled low sets status bit 4. In two-stop mode the second stop bit is ignored.
- R5: Status bits 4 and 3 are cleared only by a status write with that bit at 0, and only when a status read since the last status write returned that bit as 1. Writing 1 has no effect, and every status write discards earlier read observations.
- R6: Status bit 2 (transmit complete) is forced to 1 while `tx_en` is 0. It is also set at the end of the final stop bit if `TDRE` (status bit 7) is 1 at that moment. It is not set at that point if `TDRE` is 0.
- R7: Status bit 2 clears on a `xfer_wr` pulse, or on a status write with bit 7 at 0 after a status read saw bit 7 at 1. That write also clears `TDRE`, which commits the holding register for sending.
- R8: In `mp_mode`, the tenth bit of each received frame is stored in status bit 1. Status bit 1 and the received byte keep their values while `rx_en` is 0.
- R9: Status bit 0 is read/write, and in `mp_mode` its value is sent as the tenth bit of each transmitted frame.
- R10: A start bit that is no longer low at mid-bit (8 ticks after detection) is discarded and leaves the received byte and the flags unchanged.
- R11: `TDRE` (status bit 7) clears on a write to the holding register from the bus (address 0) or from `xfer_wr`. It sets when the holding register moves into the shifter, which happens only while `tx_en` is 1.
- R12: The data byte of each received frame is readable at address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1 |
| mp_mode | input | 1 | Tenth bit carries the marker instead of parity |
| two_stop | input | 1 | Two stop bits |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| xfer_wr | input | 1 | Transfer-controller write of the holding register |
| xfer_wdata | input | 8 | Transfer-controller data |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The receiver is fed eleven frames that cover every encoding choice:

- no tenth bit;
- even and odd parity, each with a correct and a corrupted parity bit;
- a bad first stop bit with one and with two stop bits;
- a bad second stop bit only;
- marker frames with the marker at 0 and at 1, one of them under a stale parity setting.

Each frame separates the parity path from the stop-bit path and the marker path. Directed cases then try the clear handshake with blind writes and with read observations that a write has discarded, and a start glitch shorter than half a bit. The transmit-complete timing is checked against a holding register that is empty, or already refilled, when the last stop bit ends. Finally, the marker is shown to be held while the receiver is disabled.

// File: rtl/sts_uart_pkg.sv
package sts_uart_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_START, PH_DATA, PH_EXTRA, PH_STOP1, PH_STOP2
   } phase_t;

   // status byte positions (software decodes these)
   localparam int unsigned ST_TDRE = 7;
   localparam int unsigned ST_FER  = 4;
   localparam int unsigned ST_PER  = 3;
   localparam int unsigned ST_TEND = 2;
   localparam int unsigned ST_MPB  = 1;
   localparam int unsigned ST_MPBT = 0;

   localparam logic [1:0] A_HOLD = 2'd0;
   localparam logic [1:0] A_RBUF = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
endpackage

// File: rtl/sts_uart_tx.sv
module sts_uart_tx
   import sts_uart_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_mode,
   input  logic              two_stop,
   input  logic              mp_bit,
   input  logic              pending,
   input  logic [DATA_W-1:0] data,
   output logic              load,
   output logic              last_done,
   output logic              txd
);
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = $clog2(DATA_W);
   localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);
   localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

   phase_t            ph;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] shreg;
   logic              xbit;
   logic              bit_end;

   assign load      = enable && (ph == PH_IDLE) && pending;
   assign bit_end   = tick && (cnt == LAST_T);
   assign last_done = bit_end && ((ph == PH_STOP1 && !two_stop) || ph == PH_STOP2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         shreg <= '0;
         xbit  <= 1'b0;
      end else if (!enable) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (ph == PH_IDLE) begin
         if (pending) begin
            ph    <= PH_START;
            cnt   <= '0;
            shreg <= data;
            xbit  <= mp_mode ? mp_bit : (^data ^ par_odd);
         end
      end else begin
         if (tick) cnt <= bit_end ? '0 : cnt + 1'b1;
         if (bit_end) begin
            case (ph)
               PH_START: begin
                  ph   <= PH_DATA;
                  bitn <= '0;
               end
               PH_DATA: begin
                  shreg <= shreg >> 1;
                  if (bitn == LAST_B) ph <= (par_en || mp_mode) ? PH_EXTRA : PH_STOP1;
                  else                bitn <= bitn + 1'b1;
               end
               PH_EXTRA: ph <= PH_STOP1;
               PH_STOP1: ph <= two_stop ? PH_STOP2 : PH_IDLE;
               default:  ph <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (ph)
         PH_START: txd = 1'b0;
         PH_DATA:  txd = shreg[0];
         PH_EXTRA: txd = xbit;
         default:  txd = 1'b1;
      endcase
   end

   // R2: the line idles high between frames
   assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable) |=> txd);
endmodule

// File: rtl/sts_uart_rx.sv
module sts_uart_rx
   import sts_uart_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enable,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_mode,
   input  logic              two_stop,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              stop_bad,
   output logic              par_bad,
   output logic              mp_val
);
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = $clog2(DATA_W);
   localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);
   localparam logic [CW-1:0] MID_T  = CW'(OVS / 2 - 1);
   localparam logic [BW-1:0] LAST_B = BW'(DATA_W - 1);

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         logic [SYNC_STAGES:0]   chain_w;
         assign chain_w = {chain, rxd};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= chain_w[SYNC_STAGES-1:0];
         end
         assign rx_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   phase_t            ph;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] shreg;
   logic              xbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         xbit     <= 1'b0;
         done     <= 1'b0;
         data     <= '0;
         stop_bad <= 1'b0;
         par_bad  <= 1'b0;
         mp_val   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            ph  <= PH_IDLE;
            cnt <= '0;
         end else if (tick) begin
            case (ph)
               PH_IDLE: if (!rx_s) begin
                  ph  <= PH_START;
                  cnt <= '0;
               end
               PH_START: if (cnt == MID_T) begin
                  cnt  <= '0;
                  bitn <= '0;
                  ph   <= rx_s ? PH_IDLE : PH_DATA;   // R10 glitch reject
               end else begin
                  cnt <= cnt + 1'b1;
               end
               default: if (cnt != LAST_T) begin
                  cnt <= cnt + 1'b1;
               end else begin
                  cnt <= '0;
                  case (ph)
                     PH_DATA: begin
                        shreg <= {rx_s, shreg[DATA_W-1:1]};
                        if (bitn == LAST_B) ph <= (par_en || mp_mode) ? PH_EXTRA : PH_STOP1;
                        else                bitn <= bitn + 1'b1;
                     end
                     PH_EXTRA: begin
                        xbit <= rx_s;
                        ph   <= PH_STOP1;
                     end
                     PH_STOP1: begin
                        done     <= 1'b1;
                        data     <= shreg;
                        stop_bad <= !rx_s;
                        par_bad  <= par_en && !mp_mode && (xbit != (^shreg ^ par_odd));
                        mp_val   <= xbit;
                        ph       <= two_stop ? PH_STOP2 : PH_IDLE;
                     end
                     default: ph <= PH_IDLE;
                  endcase
               end
            endcase
         end
      end
   end

   // R8: a disabled receiver never reports a frame
   assert_no_frame_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable) |=> !done);
endmodule

// File: rtl/serial_status_uart.sv
module serial_status_uart
   import sts_uart_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_mode,
   input  logic              two_stop,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              xfer_wr,
   input  logic [DATA_W-1:0] xfer_wdata,
   input  logic              rxd,
   output logic              txd
);
   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (DATA_W < 5 || DATA_W > 8) begin : g_bad_width
         $error("DATA_W must lie in 5..8");
      end
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic [DATA_W-1:0] hold_q, rbuf_q, rx_data;
   logic tdre_q, fer_q, per_q, tend_q, mpb_q, mpbt_q;
   logic seen_fer, seen_per, seen_tdre;
   logic tx_load, tx_last, rx_done, rx_stop_bad, rx_par_bad, rx_mp;
   logic st_wr, st_rd, hold_wr, commit_wr;
   logic [7:0] status;

   assign st_wr     = bus_wr && (bus_addr == A_STAT);
   assign st_rd     = bus_rd && (bus_addr == A_STAT);
   assign hold_wr   = bus_wr && (bus_addr == A_HOLD);
   assign commit_wr = st_wr && !bus_wdata[ST_TDRE] && seen_tdre;

   assign status = {tdre_q, 2'b00, fer_q, per_q, tend_q, mpb_q, mpbt_q};

   always_comb begin
      case (bus_addr)
         A_HOLD:  bus_rdata = 8'(hold_q);
         A_RBUF:  bus_rdata = 8'(rbuf_q);
         A_STAT:  bus_rdata = status;
         default: bus_rdata = 8'h00;
      endcase
   end

   sts_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(tx_en),
      .par_en(par_en), .par_odd(par_odd), .mp_mode(mp_mode), .two_stop(two_stop),
      .mp_bit(mpbt_q), .pending(!tdre_q), .data(hold_q),
      .load(tx_load), .last_done(tx_last), .txd(txd)
   );

   sts_uart_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(rx_en),
      .par_en(par_en), .par_odd(par_odd), .mp_mode(mp_mode), .two_stop(two_stop),
      .rxd(rxd), .done(rx_done), .data(rx_data), .stop_bad(rx_stop_bad),
      .par_bad(rx_par_bad), .mp_val(rx_mp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         rbuf_q    <= '0;
         tdre_q    <= 1'b1;
         fer_q     <= 1'b0;
         per_q     <= 1'b0;
         tend_q    <= 1'b1;
         mpb_q     <= 1'b0;
         mpbt_q    <= 1'b0;
         seen_fer  <= 1'b0;
         seen_per  <= 1'b0;
         seen_tdre <= 1'b0;
      end else begin
         // read observations: any status write forgets them
         if (st_wr) begin
            seen_fer  <= 1'b0;
            seen_per  <= 1'b0;
            seen_tdre <= 1'b0;
         end else if (st_rd) begin
            seen_fer  <= seen_fer  | fer_q;
            seen_per  <= seen_per  | per_q;
            seen_tdre <= seen_tdre | tdre_q;
         end

         if (rx_done && rx_stop_bad)                      fer_q <= 1'b1;
         else if (st_wr && !bus_wdata[ST_FER] && seen_fer) fer_q <= 1'b0;

         if (rx_done && rx_par_bad)                       per_q <= 1'b1;
         else if (st_wr && !bus_wdata[ST_PER] && seen_per) per_q <= 1'b0;

         if (rx_done) rbuf_q <= rx_data;
         if (rx_done && mp_mode) mpb_q <= rx_mp;
         if (st_wr) mpbt_q <= bus_wdata[ST_MPBT];

         if (xfer_wr)      hold_q <= xfer_wdata;
         else if (hold_wr) hold_q <= bus_wdata[DATA_W-1:0];

         if (xfer_wr || hold_wr || commit_wr) tdre_q <= 1'b0;
         else if (tx_load)                    tdre_q <= 1'b1;

         if (!tx_en)                      tend_q <= 1'b1;
         else if (tx_last && tdre_q)      tend_q <= 1'b1;
         else if (xfer_wr || commit_wr)   tend_q <= 1'b0;
      end
   end

   assert_fer_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fer_q) |-> $past(st_wr && !bus_wdata[ST_FER]));
   assert_per_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(per_q) |-> $past(st_wr && !bus_wdata[ST_PER]));
   assert_tend_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en) |=> tend_q);
   assert_tend_fall_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend_q) |-> $past(xfer_wr || (st_wr && !bus_wdata[ST_TDRE])));
   assert_mpb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en) |=> $stable(mpb_q));
   assert_tdre_set_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre_q) |-> $past(tx_load));
endmodule

// File: tb/test_serial_status_uart.sv
module test_serial_status_uart;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, rx_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
   logic       mp_mode = 1'b0, two_stop = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, xfer_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00, xfer_wdata = 8'h00, bus_rdata;
   logic       rxd = 1'b1, txd;

   int  nchk = 0, nfail = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   serial_status_uart i_serial_status_uart (
      .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .tx_en(tx_en), .rx_en(rx_en),
      .par_en(par_en), .par_odd(par_odd), .mp_mode(mp_mode), .two_stop(two_stop),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .xfer_wr(xfer_wr), .xfer_wdata(xfer_wdata),
      .rxd(rxd), .txd(txd)
   );

   // {data[18:11], par_en, par_odd, mp, two_stop, bad_par, mpbit, stop1, stop2, e_fer, e_per, e_mpb}
   localparam logic [18:0] RXV [11] = '{
      {8'hA5, 11'b0_0_0_0_0_0_1_1_0_0_0},
      {8'h3C, 11'b1_0_0_0_0_0_1_1_0_0_0},
      {8'h3C, 11'b1_0_0_0_1_0_1_1_0_1_0},
      {8'h81, 11'b1_1_0_0_0_0_1_1_0_0_0},
      {8'h7E, 11'b1_1_0_0_1_0_1_1_0_1_0},
      {8'h55, 11'b0_0_0_0_0_0_0_1_1_0_0},
      {8'h12, 11'b0_0_0_1_0_0_1_0_0_0_0},
      {8'h34, 11'b0_0_0_1_0_0_0_1_1_0_0},
      {8'hF0, 11'b0_0_1_0_0_1_1_1_0_0_1},
      {8'h0F, 11'b0_0_1_0_0_0_1_1_0_0_0},
      {8'h99, 11'b1_0_1_0_1_1_1_1_0_0_1}
   };

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] v);
      @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] v);
      @(negedge clk); xfer_wdata = v; xfer_wr = 1'b1;
      @(negedge clk); xfer_wr = 1'b0;
   endtask

   task automatic line_bit(input logic v);
      rxd = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send_rx(input logic [7:0] d, input logic has_x, input logic x,
                          input logic s1, input logic two, input logic s2);
      @(negedge clk);
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(d[i]);
      if (has_x) line_bit(x);
      line_bit(s1);
      if (two) line_bit(s2);
      rxd = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   task automatic capture_tx(input int nb, output logic [11:0] f);
      int w;
      w = 0;
      f = '0;
      @(negedge clk);
      while (txd !== 1'b0 && w < 400) begin
         @(negedge clk);
         w++;
      end
      repeat (8) @(negedge clk);
      f[0] = txd;
      for (int k = 1; k < nb; k++) begin
         repeat (16) @(negedge clk);
         f[k] = txd;
      end
   endtask

   function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic has_x,
                                             input logic x);
      logic [11:0] f;
      f = '0;
      f[8:1] = d;
      f[9]   = has_x ? x : 1'b1;
      f[10]  = has_x;
      return f;
   endfunction

   initial begin : watchdog
      #(1_500_000);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0]  s, d;
      logic [11:0] fr;
      logic        px;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_STAT_L, s);
      chk("R1 status reset", 12'(s), 12'h084);
      chk("R1 txd idle", 12'(txd), 12'h001);

      // table: R3 R4 R8 R12
      for (int v = 0; v < 11; v++) begin
         par_en   = RXV[v][10];
         par_odd  = RXV[v][9];
         mp_mode  = RXV[v][8];
         two_stop = RXV[v][7];
         d  = RXV[v][18:11];
         px = RXV[v][8] ? RXV[v][5] : ((par_odd ? ~^d : ^d) ^ RXV[v][6]);
         send_rx(d, RXV[v][10] | RXV[v][8], px, RXV[v][4], RXV[v][7], RXV[v][3]);
         rd(A_RBUF_L, s);
         chk("R12 received byte", 12'(s), 12'(d));
         rd(A_STAT_L, s);
         chk("R4 framing flag", 12'(s[4]), 12'(RXV[v][2]));
         chk("R3 parity flag", 12'(s[3]), 12'(RXV[v][1]));
         chk("R8 marker captured", 12'(s[1]), 12'(RXV[v][0]));
         wr(A_STAT_L, 8'h80);
         rd(A_STAT_L, s);
         chk("R5 handshake clear", 12'(s & 8'h18), 12'h000);
      end
      par_en = 1'b0; par_odd = 1'b0; mp_mode = 1'b0; two_stop = 1'b0;

      // R5 blind writes and forgotten reads
      send_rx(8'h4D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      wr(A_STAT_L, 8'hFF);
      rd(A_STAT_L, s);
      chk("R5 blind write ignored", 12'(s[4]), 12'h001);
      wr(A_STAT_L, 8'hFF);
      wr(A_STAT_L, 8'h80);
      rd(A_STAT_L, s);
      chk("R5 stale read not honoured", 12'(s[4]), 12'h001);
      wr(A_STAT_L, 8'h80);
      rd(A_STAT_L, s);
      chk("R5 fresh read then clear", 12'(s[4]), 12'h000);

      // R10 start glitch
      @(negedge clk); rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
      rd(A_RBUF_L, s);
      chk("R10 glitch keeps byte", 12'(s), 12'h04D);
      rd(A_STAT_L, s);
      chk("R10 glitch no flag", 12'(s & 8'h18), 12'h000);

      // R8 marker held while receiver off
      mp_mode = 1'b1;
      send_rx(8'hE7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      rd(A_STAT_L, s);
      chk("R8 marker one", 12'(s[1]), 12'h001);
      rx_en = 1'b0;
      send_rx(8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      rd(A_STAT_L, s);
      chk("R8 marker held", 12'(s[1]), 12'h001);
      rd(A_RBUF_L, s);
      chk("R8 byte held", 12'(s), 12'h0E7);
      rx_en = 1'b1; mp_mode = 1'b0;

      // R11 / R2 / R3 transmit with even parity
      par_en = 1'b1;
      wr(A_HOLD_L, 8'h6B);
      rd(A_STAT_L, s);
      chk("R11 TDRE cleared by write", 12'(s[7]), 12'h000);
      chk("R6 TEND while disabled", 12'(s[2]), 12'h001);
      @(negedge clk); tx_en = 1'b1;
      capture_tx(11, fr);
      chk("R2 R3 parity frame", fr, exp_frame(8'h6B, 1'b1, 1'b1));
      rd(A_STAT_L, s);
      chk("R11 TDRE set on load", 12'(s[7]), 12'h001);
      par_en = 1'b0;

      // R9 marker bit transmit
      mp_mode = 1'b1;
      wr(A_STAT_L, 8'h81);
      rd(A_STAT_L, s);
      chk("R9 marker readback", 12'(s[0]), 12'h001);
      wr(A_HOLD_L, 8'hC3);
      capture_tx(11, fr);
      chk("R9 marker in frame", fr, exp_frame(8'hC3, 1'b1, 1'b1));
      repeat (20) @(negedge clk);
      mp_mode = 1'b0;

      // R7 transfer write clears TEND, R6 sets it at end
      xfer(8'h5A);
      rd(A_STAT_L, s);
      chk("R7 xfer clears TEND", 12'(s[2]), 12'h000);
      capture_tx(10, fr);
      chk("R2 plain frame", fr, exp_frame(8'h5A, 1'b0, 1'b0));
      repeat (20) @(negedge clk);
      rd(A_STAT_L, s);
      chk("R6 TEND at end", 12'(s[2]), 12'h001);

      // R7 commit via status write; R6 no TEND when refill pending
      wr(A_HOLD_L, 8'h11);
      rd(A_STAT_L, s);
      wr(A_STAT_L, 8'h00);
      rd(A_STAT_L, s);
      chk("R7 commit clears TEND and TDRE", 12'(s & 8'h84), 12'h000);
      repeat (200) @(negedge clk);
      rd(A_STAT_L, s);
      chk("R6 no TEND with refill", 12'(s & 8'h84), 12'h080);
      repeat (200) @(negedge clk);
      rd(A_STAT_L, s);
      chk("R6 TEND after last frame", 12'(s[2]), 12'h001);

      // R6 disabling transmitter forces TEND
      xfer(8'h77);
      @(negedge clk); tx_en = 1'b0;
      repeat (2) @(negedge clk);
      rd(A_STAT_L, s);
      chk("R6 TEND on disable", 12'(s[2]), 12'h001);
      chk("R6 line idle on disable", 12'(txd), 12'h001);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   localparam logic [1:0] A_HOLD_L = 2'd0;
   localparam logic [1:0] A_RBUF_L = 2'd1;
   localparam logic [1:0] A_STAT_L = 2'd2;
endmodule